// File: doc/BRIEF.md
# Error Event Logging Controller

This block sits beside a task-flow monitor in a test setup. It records two kinds of events into two separate byte-wide log memories:

- **Error events:** sequence errors and time errors reported by the monitor.
- **Context-switch events:** each switch of the running task.

Every event becomes a four-byte record. The record carries a two-bit type code and the value of a 28-bit free-running timestamp counter, taken in the cycle the event was sampled.

A two-bit mode input sets what the block does. Its four values are idle, read back the error log, read back the switch log, and capture into both logs. During capture, each log has its own write engine. An engine stores one byte per cycle and raises a busy flag while a record is in flight. It can hold one more event while busy. A further event sets a sticky overflow flag. When its memory is full, the engine raises a full flag and drops further events. In the two read modes, a host supplies a byte address and receives the addressed byte one cycle later. The memory depth is a parameter: a small array serves simulation, and about a million bytes serves the real setup.

Top module: `evlog_ctrl`

## Requirements
- R1: Mode encoding is as follows. 2'b00 is idle: nothing is captured and `rd_data_o` reads 8'h00. 2'b01 reads the error log. 2'b10 reads the switch log. 2'b11 captures. Events that arrive outside capture are ignored, so no busy flag rises.
- R2: In a read mode, `rd_data_o` shows the byte at `rd_addr_i` of the selected log one clock after the mode and the address are sampled.
- R3: The timestamp is a 28-bit counter. It is zero after reset and increments every clock. A record stores the counter value of the cycle in which its event input was sampled high.
- R4: A record occupies four ascending byte addresses. Byte 0 is {type[1:0], 2'b00, stamp[27:24]}. Bytes 1, 2 and 3 are stamp[23:16], stamp[15:8] and stamp[7:0].
- R5: Error-log type codes are 2'b01 for a sequence error and 2'b10 for a time error. When both errors occur in the same cycle, they form a single record with code 2'b11. Switch-log records use type 2'b00. Error events never enter the switch log, and switch events never enter the error log.
- R6: An engine writes one byte per clock. Its busy flag is high for four cycles per record, starting the cycle after the event. A record queued behind another starts with no idle cycle in between.
- R7: An event that arrives while an engine is busy waits in a one-deep pending slot. An event that arrives while the slot is occupied is dropped and sets a sticky overflow flag. The two earlier records are still written in order.
- R8: Entering capture (mode becomes 2'b11 from another mode) returns both write pointers to address 0 and clears full, overflow, pending and busy. Events in that entry cycle are ignored.
- R9: After DEPTH/4 records a log's full flag rises in the cycle after the last byte is written. Later events are dropped without raising busy or changing memory.
- R10: Leaving capture stops writing. Busy falls one cycle later, the byte due on that edge is not written, and both logs keep their contents for readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode (R1) |
| seq_err_i | input | 1 | Sequence-error event, one cycle per event |
| time_err_i | input | 1 | Time-error event, one cycle per event |
| ctx_sw_i | input | 1 | Context-switch event, one cycle per event |
| rd_addr_i | input | $clog2(DEPTH) | Read byte address |
| rd_data_o | output | 8 | Read byte |
| err_busy_o | output | 1 | Error-log engine writing |
| sw_busy_o | output | 1 | Switch-log engine writing |
| err_full_o | output | 1 | Error log full |
| sw_full_o | output | 1 | Switch log full |
| err_ovf_o | output | 1 | Error-log event lost to a full pending slot |
| sw_ovf_o | output | 1 | Switch-log event lost to a full pending slot |

## Verification
- **Busy flag:** an event driven in cycle N raises busy at the next sample, stays high through N+4, and is low at N+5. A record queued behind another extends busy by exactly four cycles.
- **Overflow and full flags:** overflow is visible one cycle after the third event. Full is visible one cycle after the last byte of the final record.
- **Read data:** read bytes are due one cycle after the mode and address.
- **Sampling:** the bench drives inputs on the falling edge and samples outputs on a later falling edge, counting exactly these registers. It takes the expected timestamp from its own counter at the moment it raises an event.

// File: rtl/evlog_pkg.sv
// Shared types and constants for the event logging controller.
// Assumes a 28-bit stamp packed into a four-byte record.
package evlog_pkg;
    localparam int STAMP_W   = 28;
    localparam int REC_BYTES = 4;
    localparam int REC_W     = 8 * REC_BYTES;
    localparam int NLOGS     = 2;
    localparam int LOG_ERR   = 0;
    localparam int LOG_SW    = 1;

    typedef enum logic [1:0] {
        MD_IDLE    = 2'b00,
        MD_RD_ERR  = 2'b01,
        MD_RD_SW   = 2'b10,
        MD_CAPTURE = 2'b11
    } mode_e;

    localparam logic [1:0] TY_SEQ  = 2'b01;
    localparam logic [1:0] TY_TIME = 2'b10;
    localparam logic [1:0] TY_SW   = 2'b00;
endpackage

// File: rtl/evlog_stamp.sv
// Free-running timestamp counter.
// Starts at zero out of reset and adds one every clock.
module evlog_stamp #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] stamp_o
);
    // Count every clock; wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_o <= '0;
        else        stamp_o <= stamp_o + 1'b1;
    end
endmodule

// File: rtl/evlog_mem.sv
// Byte-wide log memory with one write port and a registered read port.
// Assumes the contents are undefined until written; there is no reset of the array.
module evlog_mem #(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    logic [7:0] mem_q [DEPTH];

    // Store one byte when the engine writes.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/evlog_writer.sv
// Write engine for one log: builds a record, streams it out one byte per
// clock, holds one pending event, and flags overflow and full.
// Assumes DEPTH is a power of two and a multiple of four.
module evlog_writer
    import evlog_pkg::*;
#(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cap_i,
    input  logic               evt_i,
    input  logic [1:0]         type_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic               we_o,
    output logic [ADDR_W-1:0]  waddr_o,
    output logic [7:0]         wdata_o,
    output logic               busy_o,
    output logic               full_o,
    output logic               ovf_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic              busy_q, pv_q, full_q, ovf_q;
    logic [1:0]        idx_q;
    logic [REC_W-1:0]  cur_q, pend_q, rec_in;
    logic [ADDR_W-1:0] wptr_q;
    logic              accept, last;

    // Pack type and stamp into the four-byte record layout.
    assign rec_in = {type_i, 2'b00, stamp_i};
    assign accept = cap_i && !start_i && evt_i && !full_q;
    assign last   = busy_q && (idx_q == 2'd3);

    // Select the record byte for the current write, MSB first.
    always_comb begin
        case (idx_q)
            2'd0:    wdata_o = cur_q[31:24];
            2'd1:    wdata_o = cur_q[23:16];
            2'd2:    wdata_o = cur_q[15:8];
            default: wdata_o = cur_q[7:0];
        endcase
    end

    assign we_o    = busy_q && cap_i;
    assign waddr_o = wptr_q;
    assign busy_o  = busy_q;
    assign full_o  = full_q;
    assign ovf_o   = ovf_q;

    // Engine state: record in flight, pending slot, pointer and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            cur_q  <= '0;
            pv_q   <= 1'b0;
            pend_q <= '0;
            wptr_q <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            pv_q   <= 1'b0;
            wptr_q <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (!cap_i) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            pv_q   <= 1'b0;
        end else if (busy_q) begin
            wptr_q <= wptr_q + 1'b1;
            idx_q  <= idx_q + 1'b1;
            if (last) begin
                if (wptr_q == LAST_ADDR) begin
                    full_q <= 1'b1;
                    busy_q <= 1'b0;
                    pv_q   <= 1'b0;
                end else if (pv_q) begin
                    cur_q <= pend_q;
                    pv_q  <= accept;
                    if (accept) pend_q <= rec_in;
                end else if (accept) begin
                    cur_q <= rec_in;
                end else begin
                    busy_q <= 1'b0;
                end
            end else if (accept) begin
                if (pv_q) begin
                    ovf_q <= 1'b1;
                end else begin
                    pv_q   <= 1'b1;
                    pend_q <= rec_in;
                end
            end
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            cur_q  <= rec_in;
        end
    end
endmodule

// File: rtl/evlog_ctrl.sv
// Event logging controller top: decodes the mode, shares one timestamp
// between an error-log engine and a switch-log engine, and serves host reads.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module evlog_ctrl
    import evlog_pkg::*;
#(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              seq_err_i,
    input  logic              time_err_i,
    input  logic              ctx_sw_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              err_busy_o,
    output logic              sw_busy_o,
    output logic              err_full_o,
    output logic              sw_full_o,
    output logic              err_ovf_o,
    output logic              sw_ovf_o
);
    logic               cap, cap_q, start;
    logic [1:0]         sel_q;
    logic [STAMP_W-1:0] stamp;

    logic [NLOGS-1:0]             evt_v, we_v, busy_v, full_v, ovf_v;
    logic [NLOGS-1:0][1:0]        typ_v;
    logic [NLOGS-1:0][ADDR_W-1:0] wa_v;
    logic [NLOGS-1:0][7:0]        wd_v, rb_v;

    assign cap   = (mode_i == MD_CAPTURE);
    assign start = cap && !cap_q;

    // Remember last cycle's capture state to find capture entry.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= cap;
    end

    // Register the mode alongside the memory read for the output mux.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= MD_IDLE;
        else        sel_q <= mode_i;
    end

    evlog_stamp #(.W(STAMP_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .stamp_o(stamp)
    );

    // Route monitor inputs to the two logs with their type codes.
    always_comb begin
        evt_v[LOG_ERR] = seq_err_i | time_err_i;
        typ_v[LOG_ERR] = {time_err_i, seq_err_i};
        evt_v[LOG_SW]  = ctx_sw_i;
        typ_v[LOG_SW]  = TY_SW;
    end

    for (genvar g = 0; g < NLOGS; g++) begin : g_log
        evlog_writer #(.DEPTH(DEPTH)) u_wr (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(start),
            .cap_i  (cap),
            .evt_i  (evt_v[g]),
            .type_i (typ_v[g]),
            .stamp_i(stamp),
            .we_o   (we_v[g]),
            .waddr_o(wa_v[g]),
            .wdata_o(wd_v[g]),
            .busy_o (busy_v[g]),
            .full_o (full_v[g]),
            .ovf_o  (ovf_v[g])
        );
        evlog_mem #(.DEPTH(DEPTH)) u_mem (
            .clk    (clk),
            .we_i   (we_v[g]),
            .waddr_i(wa_v[g]),
            .wdata_i(wd_v[g]),
            .raddr_i(rd_addr_i),
            .rdata_o(rb_v[g])
        );
    end

    // Pick the read byte of the log named by the registered mode.
    always_comb begin
        case (sel_q)
            MD_RD_ERR: rd_data_o = rb_v[LOG_ERR];
            MD_RD_SW:  rd_data_o = rb_v[LOG_SW];
            default:   rd_data_o = 8'h00;
        endcase
    end

    assign err_busy_o = busy_v[LOG_ERR];
    assign sw_busy_o  = busy_v[LOG_SW];
    assign err_full_o = full_v[LOG_ERR];
    assign sw_full_o  = full_v[LOG_SW];
    assign err_ovf_o  = ovf_v[LOG_ERR];
    assign sw_ovf_o   = ovf_v[LOG_SW];
endmodule

// File: rtl/evlog_chk.sv
// Property checker for the event logging controller, bound to the top.
module evlog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       cap_q,
    input logic [7:0] rd_data_o,
    input logic       err_busy_o,
    input logic       sw_busy_o,
    input logic       err_full_o,
    input logic       sw_full_o,
    input logic       err_ovf_o,
    input logic       sw_ovf_o
);
    // R1
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> (rd_data_o == 8'h00));

    // R10
    stop_on_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b11) |=> (!err_busy_o && !sw_busy_o));

    // R8
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !cap_q) |=> (!err_ovf_o && !sw_ovf_o && !err_full_o && !sw_full_o));

    // R9
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_full_o && cap_q && mode_i == 2'b11) |=> sw_full_o);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_busy_o) && mode_i == 2'b11) |=> sw_busy_o);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf_o && cap_q && mode_i == 2'b11) |=> err_ovf_o);
endmodule

bind evlog_ctrl evlog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .cap_q     (cap_q),
    .rd_data_o (rd_data_o),
    .err_busy_o(err_busy_o),
    .sw_busy_o (sw_busy_o),
    .err_full_o(err_full_o),
    .sw_full_o (sw_full_o),
    .err_ovf_o (err_ovf_o),
    .sw_ovf_o  (sw_ovf_o)
);

// File: tb/evlog_ctrl_tb.sv
`timescale 1ns/1ps
module evlog_ctrl_tb;
    localparam int DEPTH  = 64;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int NREC   = DEPTH / 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              seq_e = 1'b0, time_e = 1'b0, ctx = 1'b0;
    logic [ADDR_W-1:0] raddr = '0;
    logic [7:0]        rdata;
    logic              eb, sb, ef, sf, eo, so;
    logic [27:0]       tb_cnt;
    int                checks = 0, errors = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    evlog_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .seq_err_i(seq_e),
        .time_err_i(time_e), .ctx_sw_i(ctx), .rd_addr_i(raddr),
        .rd_data_o(rdata), .err_busy_o(eb), .sw_busy_o(sb),
        .err_full_o(ef), .sw_full_o(sf), .err_ovf_o(eo), .sw_ovf_o(so)
    );

    // Expected timestamp: cycles since reset release (R3).
    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= '0;
        else        tb_cnt <= tb_cnt + 1'b1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [1:0] ty, input logic [27:0] ts, input int k);
        case (k)
            0:       return {ty, 2'b00, ts[27:24]};
            1:       return ts[23:16];
            2:       return ts[15:8];
            default: return ts[7:0];
        endcase
    endfunction

    task automatic drv(input logic s, input logic t, input logic c, output logic [27:0] ts);
        @(negedge clk);
        seq_e = s; time_e = t; ctx = c;
        ts = tb_cnt;
    endtask

    task automatic idle_n(input int n);
        repeat (n) begin
            @(negedge clk);
            seq_e = 1'b0; time_e = 1'b0; ctx = 1'b0;
        end
    endtask

    // Read one record, one byte per cycle, due one cycle after address (R2, R4).
    task automatic chk_rec(input string tag, input logic [1:0] md, input int base,
                           input logic [1:0] ty, input logic [27:0] ts);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode = md; raddr = ADDR_W'(base + k);
            @(negedge clk);
            check($sformatf("%s R2 R4 byte %0d", tag, k), {24'h0, rdata}, {24'h0, exp_byte(ty, ts, k)});
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset rd_data", {24'h0, rdata}, 32'h0);
        check("R1 reset flags", {26'h0, eb, sb, ef, sf, eo, so}, 32'h0);
    endtask

    task automatic t_idle_ignore();
        logic [27:0] ts;
        drv(1'b1, 1'b0, 1'b1, ts);
        idle_n(1);
        check("R1 idle event ignored", {30'h0, eb, sb}, 32'h0);
    endtask

    task automatic t_session1();
        logic [27:0] ts0, ts1, ts2, tsa, tsb, tsc, tsd, tse, tsf;
        @(negedge clk); mode = 2'b11;
        idle_n(2);
        drv(1'b1, 1'b0, 1'b1, ts0);
        for (int i = 1; i <= 4; i++) begin
            idle_n(1);
            check($sformatf("R6 busy cycle %0d", i), {30'h0, eb, sb}, 32'h3);
        end
        idle_n(1);
        check("R6 busy done", {30'h0, eb, sb}, 32'h0);
        drv(1'b0, 1'b1, 1'b0, ts1); idle_n(5);
        drv(1'b1, 1'b1, 1'b0, ts2); idle_n(5);
        drv(1'b1, 1'b0, 1'b0, tsa);
        drv(1'b0, 1'b1, 1'b0, tsb);
        drv(1'b1, 1'b1, 1'b0, tsc);
        idle_n(1);
        check("R7 overflow set", {31'h0, eo}, 32'h1);
        check("R7 switch log no overflow", {31'h0, so}, 32'h0);
        idle_n(10);
        drv(1'b0, 1'b1, 1'b0, tsd); idle_n(6);
        drv(1'b0, 1'b0, 1'b1, tse);
        for (int i = 1; i <= 3; i++) begin
            idle_n(1);
            check("R6 chained busy", {31'h0, sb}, 32'h1);
        end
        drv(1'b0, 1'b0, 1'b1, tsf);
        check("R6 chained busy at second event", {31'h0, sb}, 32'h1);
        for (int i = 5; i <= 8; i++) begin
            idle_n(1);
            check($sformatf("R6 chained busy cycle %0d", i), {31'h0, sb}, 32'h1);
        end
        idle_n(1);
        check("R6 chained busy done", {31'h0, sb}, 32'h0);
        chk_rec("R3 R5 seq", 2'b01, 0, 2'b01, ts0);
        chk_rec("R5 time", 2'b01, 4, 2'b10, ts1);
        chk_rec("R5 both", 2'b01, 8, 2'b11, ts2);
        chk_rec("R7 first", 2'b01, 12, 2'b01, tsa);
        chk_rec("R7 pending", 2'b01, 16, 2'b10, tsb);
        chk_rec("R7 dropped third", 2'b01, 20, 2'b10, tsd);
        chk_rec("R5 switch type", 2'b10, 0, 2'b00, ts0);
        chk_rec("R6 chained first", 2'b10, 4, 2'b00, tse);
        chk_rec("R6 chained second", 2'b10, 8, 2'b00, tsf);
        if (tsc == 28'h0) $display("note: third stamp zero");
    endtask

    task automatic t_session2();
        logic [27:0] tsr [NREC];
        logic [27:0] tsx;
        @(negedge clk); mode = 2'b00;
        @(negedge clk); mode = 2'b11;
        idle_n(1);
        check("R8 overflow cleared on entry", {31'h0, eo}, 32'h0);
        for (int i = 0; i < NREC; i++) begin
            if (i == NREC - 1) check("R9 not full before last", {31'h0, sf}, 32'h0);
            drv(1'b0, 1'b0, 1'b1, tsr[i]);
            idle_n(4);
        end
        idle_n(1);
        check("R9 full raised", {31'h0, sf}, 32'h1);
        drv(1'b0, 1'b0, 1'b1, tsx);
        idle_n(1);
        check("R9 no busy when full", {31'h0, sb}, 32'h0);
        idle_n(5);
        chk_rec("R8 pointer restarts", 2'b10, 0, 2'b00, tsr[0]);
        chk_rec("R9 last record intact", 2'b10, DEPTH - 4, 2'b00, tsr[NREC - 1]);
        // Session 3: entry-cycle event is ignored, leaving capture halts writes.
        @(negedge clk); mode = 2'b00;
        @(negedge clk); mode = 2'b11; ctx = 1'b1;
        idle_n(1);
        check("R8 entry cycle event ignored", {31'h0, sb}, 32'h0);
        check("R8 full cleared on entry", {31'h0, sf}, 32'h0);
        drv(1'b0, 1'b0, 1'b1, tsx);
        idle_n(1);
        check("R10 busy before leave", {31'h0, sb}, 32'h1);
        mode = 2'b00;
        idle_n(1);
        check("R10 busy drops after leave", {31'h0, sb}, 32'h0);
        chk_rec("R10 contents kept", 2'b10, 0, 2'b00, tsr[0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_ignore();
        t_session1();
        t_session2();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule